// File: doc/BRIEF.md
# Token-Counting Coherence Permission Controller

This block sits beside a private cache and decides, for a handful of cache blocks, whether the local processor may read or write each one. It keeps no classic stable-state coherence machine. The only per-block state it holds is how many coherence tokens the cache currently owns, together with the block's data. Every block in the system has a fixed total of `TOKENS` tokens. Tokens are never made or lost: they move between caches, memory and messages in flight.

A load may complete while the cache owns at least one token. A store needs every token. When the count is too low, the controller sends a transient request. The request is only a hint. If enough tokens do not arrive within `TIMEOUT` cycles, the request is sent again. After `MAX_RETRY` attempts fail, the controller raises a persistent-request escalation toward an external arbiter. It then falls back to a slower `LONG_TIMEOUT` reissue interval.

Incoming messages carry tokens (optionally with data), or carry read and write requests that another cache has forwarded here. Forwarded requests make the controller give tokens away. An eviction sends all held tokens and the data toward memory, with no handshake.

Top module: `token_perm_ctrl`

## Requirements
- R1: After synchronous reset every block holds zero tokens, and `cpu_grant`, `out_valid`, `persist_req` and `err_flag` are all low.
- R2: A load (`cpu_op`=0) to a block holding at least one token is granted in the cycle after it is presented. `cpu_rdata` then carries the block's current data.
- R3: A store (`cpu_op`=1) is granted only while the block holds all `TOKENS` tokens. When granted, its `cpu_wdata` becomes the block's data.
- R4: An incoming token message (`in_kind`=0) adds `in_tokens` to the block's count. It writes `in_data` to the block when `in_has_data` is 1.
- R5: A forwarded write (`in_kind`=2) makes the controller send all its tokens for that block with data (`out_kind`=2) on the next cycle. If the block holds no tokens, nothing is sent.
- R6: A forwarded read (`in_kind`=1) sends exactly one token with data (`out_kind`=2), and only when the block holds more than one token. Otherwise nothing is sent.
- R7: An eviction (`cpu_op`=2) is granted at once with no handshake. If any tokens are held, they are all sent with data toward memory (`out_kind`=3), and the block's count drops to zero.
- R8: A load or store without enough tokens sends a request (`out_kind`=0 for read, 1 for write) two cycles after it is presented. The request is resent every `TIMEOUT`+1 cycles. An arriving token message for the pending block restarts that wait.
- R9: When the `MAX_RETRY`-th request times out, `persist_req` rises and `persist_blk` names the block. `persist_req` stays high until the access is granted, and requests are then resent only after `LONG_TIMEOUT` cycles.
- R10: A token message that would lift a block's count above `TOKENS` sets the sticky `err_flag`, and the count saturates at `TOKENS`.
- R11: A token message without data to a block holding zero tokens sets the sticky `err_flag`.
- R12: An access decision waits one cycle when an incoming message targets the same block in the same cycle. A forwarded-request response takes the output port ahead of a pending request, which goes out on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor access present, held until granted |
| cpu_op | input | 2 | 0 load, 1 store, 2 evict |
| cpu_blk | input | BLK_W | Block index of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_grant | output | 1 | One-cycle pulse: access completed |
| cpu_rdata | output | DATA_W | Load data, valid with grant |
| in_valid | input | 1 | Incoming message valid |
| in_kind | input | 2 | 0 tokens, 1 forwarded read, 2 forwarded write, 3 ignored |
| in_blk | input | BLK_W | Block of the incoming message |
| in_tokens | input | CNT_W | Tokens carried (token messages only) |
| in_has_data | input | 1 | Message carries block data |
| in_data | input | DATA_W | Block data |
| out_valid | output | 1 | Outgoing message valid |
| out_kind | output | 2 | 0 read request, 1 write request, 2 tokens to requester, 3 tokens to memory |
| out_blk | output | BLK_W | Block of the outgoing message |
| out_tokens | output | CNT_W | Tokens sent |
| out_data | output | DATA_W | Data sent with tokens |
| persist_req | output | 1 | Persistent-request escalation active |
| persist_blk | output | BLK_W | Block of the escalation |
| err_flag | output | 1 | Sticky protocol error |

## Verification
The bench aims at timing corners where a slip is visible only in cycle counts:
- **Timer restart.** A token arrival midway through a wait must push the next reissue later. A controller that ignored the arrival would resend at the unshifted time.
- **Escalation.** The escalation must follow exactly the fourth timed-out request. A controller off by one would escalate one request early or late.
- **Long reissue.** After escalation, the first reissue must be spaced by the long timeout. A controller that kept the short timeout would reissue too soon.
- **Same-block races.** A forwarded read arriving with a load to the same block, or tokens arriving with a pending store, must delay the grant by one cycle. A controller that granted at once would act on a stale count.
- **Port priority.** A forward response colliding with a request issue must win the port. A controller that dropped either message would leave a token missing or a request unsent.
- **Saturation and errors.** Saturation at the token total, and the dataless-first-token error, are each driven deliberately. A controller that wrapped its count or accepted tokens with no valid data would show through `err_flag` or the size of a later forward response.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  typedef enum logic [1:0] {
    IN_TOKENS = 2'd0,
    IN_FWD_RD = 2'd1,
    IN_FWD_WR = 2'd2,
    IN_NONE   = 2'd3
  } in_kind_e;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_EVICT = 2'd2,
    OP_NOP   = 2'd3
  } cpu_op_e;

  typedef enum logic [1:0] {
    OUT_REQ_RD = 2'd0,
    OUT_REQ_WR = 2'd1,
    OUT_GIVE   = 2'd2,
    OUT_WB     = 2'd3
  } out_kind_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_ISSUE  = 3'd1,
    S_WAIT   = 3'd2,
    S_PISSUE = 3'd3,
    S_PWAIT  = 3'd4
  } miss_state_e;

endpackage

// File: rtl/tpc_data_ram.sv
module tpc_data_ram #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/tpc_token_bank.sv
module tpc_token_bank #(
  parameter int NUM_BLOCKS = 4,
  parameter int TOKENS     = 4,
  parameter int BLK_W      = 2,
  parameter int CNT_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_en,
  input  logic [BLK_W-1:0] add_blk,
  input  logic [CNT_W-1:0] add_n,
  input  logic             take_en,
  input  logic [BLK_W-1:0] take_blk,
  input  logic [CNT_W-1:0] take_n,
  output logic [CNT_W-1:0] cnt_o [NUM_BLOCKS],
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] T_CNT  = CNT_W'(TOKENS);
  localparam logic [CNT_W:0]   T_WIDE = (CNT_W+1)'(TOKENS);

  logic [CNT_W-1:0] cnt_q [NUM_BLOCKS];
  logic [CNT_W:0]   add_sum;

  always_comb begin
    add_sum = {1'b0, cnt_q[add_blk]} + {1'b0, add_n};
    ovf_o   = add_en && (add_sum > T_WIDE);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (rst) begin
        cnt_q[i] <= '0;
      end else if (add_en && add_blk == BLK_W'(i)) begin
        cnt_q[i] <= (add_sum > T_WIDE) ? T_CNT : add_sum[CNT_W-1:0];
      end else if (take_en && take_blk == BLK_W'(i)) begin
        cnt_q[i] <= cnt_q[i] - take_n;
      end
    end
  end

  assign cnt_o = cnt_q;

  // R7
  take_le_held_chk: assert property (@(posedge clk) disable iff (rst)
    take_en |-> (take_n <= cnt_q[take_blk]));

  for (genvar gi = 0; gi < NUM_BLOCKS; gi++) begin : g_cap
    // R10
    cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
      (add_en && add_blk == BLK_W'(gi)) |=> (cnt_q[gi] <= T_CNT));
  end

endmodule

// File: rtl/tpc_miss_ctrl.sv
module tpc_miss_ctrl #(
  parameter int TIMEOUT      = 8,
  parameter int LONG_TIMEOUT = 32,
  parameter int MAX_RETRY    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic clear,
  input  logic port_free,
  input  logic tok_arrived,
  output logic issue,
  output logic escalate,
  output logic busy
);
  import tpc_pkg::*;

  localparam int TMR_W = $clog2(LONG_TIMEOUT + 1);
  localparam int RTY_W = $clog2(MAX_RETRY + 1);
  localparam logic [TMR_W-1:0] SHORT_END = TMR_W'(TIMEOUT - 1);
  localparam logic [TMR_W-1:0] LONG_END  = TMR_W'(LONG_TIMEOUT - 1);
  localparam logic [RTY_W-1:0] RTY_MAX   = RTY_W'(MAX_RETRY);

  miss_state_e      state_q;
  logic [TMR_W-1:0] timer_q;
  logic [RTY_W-1:0] retry_q;

  assign issue    = !clear && port_free && (state_q == S_ISSUE || state_q == S_PISSUE);
  assign escalate = (state_q == S_PISSUE) || (state_q == S_PWAIT);
  assign busy     = (state_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state_q <= S_IDLE;
      timer_q <= '0;
      retry_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start) state_q <= S_ISSUE;
        S_ISSUE: if (port_free) begin
          state_q <= S_WAIT;
          timer_q <= '0;
          retry_q <= retry_q + 1'b1;
        end
        S_WAIT: begin
          if (tok_arrived) begin
            timer_q <= '0;
          end else if (timer_q == SHORT_END) begin
            timer_q <= '0;
            state_q <= (retry_q >= RTY_MAX) ? S_PWAIT : S_ISSUE;
          end else begin
            timer_q <= timer_q + 1'b1;
          end
        end
        S_PISSUE: if (port_free) begin
          state_q <= S_PWAIT;
          timer_q <= '0;
        end
        S_PWAIT: begin
          if (tok_arrived) begin
            timer_q <= '0;
          end else if (timer_q == LONG_END) begin
            timer_q <= '0;
            state_q <= S_PISSUE;
          end else begin
            timer_q <= timer_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R9
  esc_after_retries_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(escalate) |-> ($past(retry_q) == RTY_MAX));

  // R8
  retry_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && !escalate) |-> (retry_q < RTY_MAX));

endmodule

// File: rtl/token_perm_ctrl.sv
module token_perm_ctrl #(
  parameter int NUM_BLOCKS   = 4,
  parameter int TOKENS       = 4,
  parameter int DATA_W       = 32,
  parameter int TIMEOUT      = 8,
  parameter int LONG_TIMEOUT = 32,
  parameter int MAX_RETRY    = 4,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int CNT_W = $clog2(TOKENS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic [1:0]        cpu_op,
  input  logic [BLK_W-1:0]  cpu_blk,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_grant,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              in_valid,
  input  logic [1:0]        in_kind,
  input  logic [BLK_W-1:0]  in_blk,
  input  logic [CNT_W-1:0]  in_tokens,
  input  logic              in_has_data,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [BLK_W-1:0]  out_blk,
  output logic [CNT_W-1:0]  out_tokens,
  output logic [DATA_W-1:0] out_data,
  output logic              persist_req,
  output logic [BLK_W-1:0]  persist_blk,
  output logic              err_flag
);
  import tpc_pkg::*;

  localparam logic [CNT_W-1:0] T_CNT = CNT_W'(TOKENS);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt [NUM_BLOCKS];
  logic [CNT_W-1:0] cnt_in, cnt_cpu;
  logic [DATA_W-1:0] rd_cpu, rd_in;
  logic in_msg, msg_tok, fwd_rd, fwd_wr, fwd_send;
  logic [CNT_W-1:0] fwd_n;
  logic op_ld, op_st, op_ev, cpu_live, perm;
  logic grant_ldst, ev_go, ev_send, start, port_free, tok_arrived;
  logic ram_in_we, ram_we, ovf, dataless;
  logic [BLK_W-1:0]  ram_waddr;
  logic [DATA_W-1:0] ram_wdata;
  logic issue, escalate, busy;

  logic              cpu_grant_q;
  logic [DATA_W-1:0] cpu_rdata_q;
  logic              out_valid_q;
  out_kind_e         out_kind_q;
  logic [BLK_W-1:0]  out_blk_q;
  logic [CNT_W-1:0]  out_tokens_q;
  logic [DATA_W-1:0] out_data_q;
  logic [BLK_W-1:0]  pblk_q;
  logic              err_q;

  assign cnt_in  = cnt[in_blk];
  assign cnt_cpu = cnt[cpu_blk];

  // incoming message decode and forward response
  always_comb begin
    in_msg   = in_valid && (in_kind_e'(in_kind) != IN_NONE);
    msg_tok  = in_valid && (in_kind_e'(in_kind) == IN_TOKENS);
    fwd_rd   = in_valid && (in_kind_e'(in_kind) == IN_FWD_RD);
    fwd_wr   = in_valid && (in_kind_e'(in_kind) == IN_FWD_WR);
    fwd_send = (fwd_wr && cnt_in != '0) || (fwd_rd && cnt_in > ONE);
    fwd_n    = fwd_wr ? cnt_in : ONE;
    ram_in_we = msg_tok && in_has_data;
    dataless  = msg_tok && !in_has_data && (cnt_in == '0) && (in_tokens != '0);
  end

  // processor access decision
  always_comb begin
    op_ld    = cpu_op_e'(cpu_op) == OP_LOAD;
    op_st    = cpu_op_e'(cpu_op) == OP_STORE;
    op_ev    = cpu_op_e'(cpu_op) == OP_EVICT;
    cpu_live = cpu_valid && !cpu_grant_q && !(in_msg && in_blk == cpu_blk);
    perm     = (op_ld && cnt_cpu != '0) || (op_st && cnt_cpu == T_CNT);
    grant_ldst = cpu_live && perm && !(op_st && ram_in_we);
    ev_go    = cpu_live && op_ev && !busy && (cnt_cpu == '0 || !fwd_send);
    ev_send  = ev_go && (cnt_cpu != '0);
    start    = cpu_valid && !cpu_grant_q && (op_ld || op_st) && !grant_ldst && !busy;
    port_free   = !fwd_send && !ev_send;
    tok_arrived = msg_tok && (in_blk == cpu_blk);
    ram_we    = ram_in_we || (grant_ldst && op_st);
    ram_waddr = ram_in_we ? in_blk : cpu_blk;
    ram_wdata = ram_in_we ? in_data : cpu_wdata;
  end

  tpc_token_bank #(
    .NUM_BLOCKS(NUM_BLOCKS), .TOKENS(TOKENS), .BLK_W(BLK_W), .CNT_W(CNT_W)
  ) u_bank (
    .clk(clk), .rst(rst),
    .add_en(msg_tok), .add_blk(in_blk), .add_n(in_tokens),
    .take_en(fwd_send || ev_send),
    .take_blk(fwd_send ? in_blk : cpu_blk),
    .take_n(fwd_send ? fwd_n : cnt_cpu),
    .cnt_o(cnt), .ovf_o(ovf)
  );

  tpc_data_ram #(.DEPTH(NUM_BLOCKS), .DATA_W(DATA_W), .ADDR_W(BLK_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr_a(cpu_blk), .rdata_a(rd_cpu), .raddr_b(in_blk), .rdata_b(rd_in)
  );

  tpc_miss_ctrl #(
    .TIMEOUT(TIMEOUT), .LONG_TIMEOUT(LONG_TIMEOUT), .MAX_RETRY(MAX_RETRY)
  ) u_miss (
    .clk(clk), .rst(rst), .start(start), .clear(grant_ldst),
    .port_free(port_free), .tok_arrived(tok_arrived),
    .issue(issue), .escalate(escalate), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_grant_q  <= 1'b0;
      cpu_rdata_q  <= '0;
      out_valid_q  <= 1'b0;
      out_kind_q   <= OUT_REQ_RD;
      out_blk_q    <= '0;
      out_tokens_q <= '0;
      out_data_q   <= '0;
      pblk_q       <= '0;
      err_q        <= 1'b0;
    end else begin
      cpu_grant_q <= grant_ldst || ev_go;
      if (grant_ldst && op_ld) cpu_rdata_q <= rd_cpu;
      out_valid_q <= fwd_send || ev_send || issue;
      if (fwd_send) begin
        out_kind_q   <= OUT_GIVE;
        out_blk_q    <= in_blk;
        out_tokens_q <= fwd_n;
        out_data_q   <= rd_in;
      end else if (ev_send) begin
        out_kind_q   <= OUT_WB;
        out_blk_q    <= cpu_blk;
        out_tokens_q <= cnt_cpu;
        out_data_q   <= rd_cpu;
      end else if (issue) begin
        out_kind_q   <= op_st ? OUT_REQ_WR : OUT_REQ_RD;
        out_blk_q    <= cpu_blk;
        out_tokens_q <= '0;
        out_data_q   <= '0;
      end
      if (start) pblk_q <= cpu_blk;
      err_q <= err_q || ovf || dataless;
    end
  end

  assign cpu_grant   = cpu_grant_q;
  assign cpu_rdata   = cpu_rdata_q;
  assign out_valid   = out_valid_q;
  assign out_kind    = out_kind_q;
  assign out_blk     = out_blk_q;
  assign out_tokens  = out_tokens_q;
  assign out_data    = out_data_q;
  assign persist_req = escalate;
  assign persist_blk = pblk_q;
  assign err_flag    = err_q;

  // R3
  store_perm_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_grant && $past(cpu_op) == 2'd1) |-> ($past(cnt_cpu) == T_CNT));

  // R5
  give_has_tokens_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_kind == 2'd2 || out_kind == 2'd3)) |-> (out_tokens != '0));

  // R8
  req_no_tokens_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_kind == 2'd0 || out_kind == 2'd1)) |-> (out_tokens == '0));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(err_flag) |-> err_flag);

endmodule

// File: tb/tb_token_perm_ctrl.sv
module tb_token_perm_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NB   = 4;
  localparam int T    = 4;
  localparam int DW   = 32;
  localparam int TMO  = 8;
  localparam int LTMO = 32;
  localparam int MR   = 4;
  localparam int BW   = 2;
  localparam int CW   = 3;

  localparam int K_TOK = 0, K_FRD = 1, K_FWR = 2, K_NONE = 3;
  localparam int OPL = 0, OPS = 1, OPE = 2;
  localparam int O_RRD = 0, O_RWR = 1, O_GIVE = 2, O_WB = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_valid = 1'b0;
  logic [1:0] cpu_op = 2'd0;
  logic [BW-1:0] cpu_blk = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_grant;
  logic [DW-1:0] cpu_rdata;
  logic in_valid = 1'b0;
  logic [1:0] in_kind = 2'd3;
  logic [BW-1:0] in_blk = '0;
  logic [CW-1:0] in_tokens = '0;
  logic in_has_data = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic [1:0] out_kind;
  logic [BW-1:0] out_blk;
  logic [CW-1:0] out_tokens;
  logic [DW-1:0] out_data;
  logic persist_req;
  logic [BW-1:0] persist_blk;
  logic err_flag;

  int checks = 0;
  int fails  = 0;
  int mcnt [NB];
  logic [DW-1:0] mdat [NB];
  int req_at [16];
  int nreq;
  int esc_at;

  always #(CLK_PERIOD/2) clk = ~clk;

  token_perm_ctrl #(
    .NUM_BLOCKS(NB), .TOKENS(T), .DATA_W(DW), .TIMEOUT(TMO),
    .LONG_TIMEOUT(LTMO), .MAX_RETRY(MR)
  ) dut (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_op(cpu_op),
    .cpu_blk(cpu_blk), .cpu_wdata(cpu_wdata), .cpu_grant(cpu_grant),
    .cpu_rdata(cpu_rdata), .in_valid(in_valid), .in_kind(in_kind),
    .in_blk(in_blk), .in_tokens(in_tokens), .in_has_data(in_has_data),
    .in_data(in_data), .out_valid(out_valid), .out_kind(out_kind),
    .out_blk(out_blk), .out_tokens(out_tokens), .out_data(out_data),
    .persist_req(persist_req), .persist_blk(persist_blk), .err_flag(err_flag)
  );

  function automatic int exp_give(input int m, input bit wr);
    if (wr) return m;
    return (m > 1) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cpu_valid = 1'b0;
    in_valid = 1'b0;
    in_kind = 2'(K_NONE);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NB; i++) begin
      mcnt[i] = 0;
      mdat[i] = '0;
    end
    @(negedge clk);
  endtask

  task automatic drive_msg(input int kind, input int b, input int n, input bit hd, input logic [DW-1:0] d);
    in_valid = 1'b1;
    in_kind = 2'(kind);
    in_blk = BW'(b);
    in_tokens = CW'(n);
    in_has_data = hd;
    in_data = d;
  endtask

  task automatic release_msg();
    in_valid = 1'b0;
    in_kind = 2'(K_NONE);
  endtask

  task automatic send_msg(input int kind, input int b, input int n, input bit hd, input logic [DW-1:0] d);
    drive_msg(kind, b, n, hd, d);
    @(negedge clk);
    release_msg();
  endtask

  task automatic give_tokens(input int b, input int n, input bit hd, input logic [DW-1:0] d);
    send_msg(K_TOK, b, n, hd, d);
    chk("R4", "no output after token message", out_valid, 0);
    mcnt[b] += n;
    if (hd) mdat[b] = d;
  endtask

  task automatic forward(input int b, input bit wr);
    automatic int g = exp_give(mcnt[b], wr);
    send_msg(wr ? K_FWR : K_FRD, b, 0, 1'b0, '0);
    if (wr) chk("R5", "fwd write sends", out_valid, g != 0);
    else    chk("R6", "fwd read sends", out_valid, g != 0);
    if (g != 0) begin
      chk(wr ? "R5" : "R6", "give kind", out_kind, O_GIVE);
      chk(wr ? "R5" : "R6", "give tokens", out_tokens, g);
      chk(wr ? "R5" : "R6", "give block", out_blk, b);
      chk(wr ? "R5" : "R6", "give data", out_data, mdat[b]);
    end
    mcnt[b] -= g;
  endtask

  task automatic access_hit(input int op, input int b, input logic [DW-1:0] wd);
    automatic int m = mcnt[b];
    cpu_valid = 1'b1;
    cpu_op = 2'(op);
    cpu_blk = BW'(b);
    cpu_wdata = wd;
    @(negedge clk);
    cpu_valid = 1'b0;
    if (op == OPL) begin
      chk("R2", "load grant", cpu_grant, 1);
      chk("R2", "load data", cpu_rdata, mdat[b]);
    end else if (op == OPS) begin
      chk("R3", "store grant", cpu_grant, 1);
      mdat[b] = wd;
    end else begin
      chk("R7", "evict grant", cpu_grant, 1);
      chk("R7", "evict writeback", out_valid, m != 0);
      if (m != 0) begin
        chk("R7", "writeback kind", out_kind, O_WB);
        chk("R7", "writeback tokens", out_tokens, m);
        chk("R7", "writeback data", out_data, mdat[b]);
      end
      mcnt[b] = 0;
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin : main
    void'($urandom(32'h5eed_0042));
    do_reset();

    // R1 reset state
    chk("R1", "grant after reset", cpu_grant, 0);
    chk("R1", "out_valid after reset", out_valid, 0);
    chk("R1", "persist after reset", persist_req, 0);
    chk("R1", "err after reset", err_flag, 0);

    // R8 / R9 store miss with no tokens ever supplied until escalation
    cpu_valid = 1'b1; cpu_op = 2'(OPS); cpu_blk = 2'd2; cpu_wdata = 32'hCAFE_0002;
    nreq = 0; esc_at = -1;
    for (int n = 1; n <= 72; n++) begin
      @(negedge clk);
      if (out_valid && out_kind == 2'(O_RWR)) begin
        if (nreq < 16) req_at[nreq] = n;
        nreq++;
      end
      if (persist_req && esc_at < 0) esc_at = n;
    end
    chk("R8", "first request cycle", req_at[0], 2);
    chk("R8", "second request cycle", req_at[1], 2 + TMO + 1);
    chk("R9", "escalation cycle", esc_at, 2 + MR * (TMO + 1) - 1);
    chk("R9", "reissue after long timeout", req_at[MR], esc_at + LTMO + 1);
    chk("R9", "request count", nreq, MR + 1);
    chk("R9", "persist block", persist_blk, 2);
    drive_msg(K_TOK, 2, T, 1'b1, 32'h1111_2222);
    @(negedge clk);
    release_msg();
    chk("R12", "grant deferred on same-block message", cpu_grant, 0);
    @(negedge clk);
    cpu_valid = 1'b0;
    chk("R9", "grant after tokens", cpu_grant, 1);
    chk("R9", "escalation dropped", persist_req, 0);
    mcnt[2] = T; mdat[2] = 32'hCAFE_0002;
    @(negedge clk);
    access_hit(OPL, 2, '0);

    // R8 timer restart on token arrival
    do_reset();
    cpu_valid = 1'b1; cpu_op = 2'(OPS); cpu_blk = 2'd3; cpu_wdata = 32'hBEEF_0003;
    nreq = 0;
    for (int n = 1; n <= 18; n++) begin
      @(negedge clk);
      if (n == 7) release_msg();
      if (out_valid && out_kind == 2'(O_RWR)) begin
        if (nreq < 16) req_at[nreq] = n;
        nreq++;
      end
      if (n == 6) drive_msg(K_TOK, 3, 1, 1'b1, 32'h3333_0001);
    end
    chk("R8", "restart: first request", req_at[0], 2);
    chk("R8", "restart: delayed reissue", req_at[1], 7 + TMO + 1);
    chk("R8", "restart: request count", nreq, 2);
    drive_msg(K_TOK, 3, T - 1, 1'b0, '0);
    @(negedge clk);
    release_msg();
    chk("R12", "store waits for same-block tokens", cpu_grant, 0);
    @(negedge clk);
    cpu_valid = 1'b0;
    chk("R3", "store granted with all tokens", cpu_grant, 1);
    mcnt[3] = T; mdat[3] = 32'hBEEF_0003;
    chk("R11", "no error for dataless top-up", err_flag, 0);
    @(negedge clk);
    access_hit(OPL, 3, '0);

    // R12 forward response wins the port over a request issue
    do_reset();
    give_tokens(0, 2, 1'b1, 32'hA0A0_0000);
    cpu_valid = 1'b1; cpu_op = 2'(OPL); cpu_blk = 2'd1;
    @(negedge clk);
    chk("R12", "nothing out before issue", out_valid, 0);
    drive_msg(K_FWR, 0, 0, 1'b0, '0);
    @(negedge clk);
    release_msg();
    chk("R12", "forward response first", out_kind, O_GIVE);
    chk("R5", "forward write gives all", out_tokens, 2);
    mcnt[0] = 0;
    @(negedge clk);
    chk("R12", "request follows", out_valid, 1);
    chk("R8", "read request kind", out_kind, O_RRD);
    chk("R8", "read request block", out_blk, 1);
    drive_msg(K_TOK, 1, 1, 1'b1, 32'h0101_0101);
    @(negedge clk);
    release_msg();
    @(negedge clk);
    cpu_valid = 1'b0;
    chk("R2", "load granted after token", cpu_grant, 1);
    chk("R2", "load data after token", cpu_rdata, 32'h0101_0101);
    mcnt[1] = 1; mdat[1] = 32'h0101_0101;
    @(negedge clk);

    // R12 load and forwarded read to same block together
    cpu_valid = 1'b1; cpu_op = 2'(OPL); cpu_blk = 2'd1;
    drive_msg(K_FRD, 1, 0, 1'b0, '0);
    @(negedge clk);
    release_msg();
    chk("R6", "single token not given", out_valid, 0);
    chk("R12", "load deferred by forward", cpu_grant, 0);
    @(negedge clk);
    cpu_valid = 1'b0;
    chk("R12", "load granted next cycle", cpu_grant, 1);
    @(negedge clk);

    // R7 evict then load misses
    access_hit(OPE, 1, '0);
    cpu_valid = 1'b1; cpu_op = 2'(OPL); cpu_blk = 2'd1;
    @(negedge clk);
    @(negedge clk);
    chk("R7", "load after evict requests", out_kind, O_RRD);
    give_tokens(1, 1, 1'b1, 32'h7777_0001);
    @(negedge clk);
    cpu_valid = 1'b0;
    @(negedge clk);

    // Constrained random mix
    for (int it = 0; it < 400; it++) begin
      automatic int b = int'($urandom % NB);
      automatic int m = mcnt[b];
      automatic int sel = int'($urandom % 6);
      case (sel)
        0, 1: if (m < T) give_tokens(b, 1 + int'($urandom % (T - m)),
                                     (m == 0) ? 1'b1 : 1'($urandom % 2), $urandom);
        2: forward(b, 1'($urandom % 2));
        3: if (m >= 1) access_hit(OPL, b, '0);
        4: if (m == T) access_hit(OPS, b, $urandom);
           else give_tokens(b, T - m, (m == 0) ? 1'b1 : 1'b0, $urandom);
        default: if ($urandom % 3 == 0) access_hit(OPE, b, '0);
      endcase
    end
    chk("R10", "no error in legal traffic", err_flag, 0);

    // R10 overflow and saturation
    do_reset();
    give_tokens(0, T, 1'b1, 32'hF00D_0000);
    chk("R10", "no error at full count", err_flag, 0);
    send_msg(K_TOK, 0, 1, 1'b0, '0);
    @(negedge clk);
    chk("R10", "overflow sets error", err_flag, 1);
    forward(0, 1'b1);
    @(negedge clk);
    chk("R10", "error stays set", err_flag, 1);

    // R11 dataless first token
    do_reset();
    send_msg(K_TOK, 2, 1, 1'b0, '0);
    @(negedge clk);
    chk("R11", "dataless token to empty block", err_flag, 1);

    finish_run();
  end

endmodule